// File: doc/BRIEF.md
# Split-Partition Write-Back Cache

This block is a direct-mapped cache placed between one processor-side request port and a slow word-wide external memory. A single array serves both instruction fetches and data loads and stores, which lets one instance sit on a shared bus and cache both kinds of traffic. Stores are kept in the cache (write-back). A store that misses first brings the whole block in and then merges into it (write-allocate).

When the `SPLIT_EN` parameter is set, the block array is partitioned. The most significant index bit is taken from the instruction/data flag instead of the address, so data lives only in the lower half of the blocks and instructions only in the upper half. Every tag holds all address bits above the word select, so the address bit that the index gives up is still compared. Only one miss is handled at a time. A flush request writes every dirty block back to memory, invalidates the whole array and then pulses a done flag.

Handshake rules: a request is held stable until `req_ready` is seen high, and it completes on that clock edge. On a read, `req_rdata` is valid in the same cycle. A memory transfer completes on an edge where both `mem_req` and `mem_ack` are high, and `mem_rdata` is sampled on that edge.

Top module: `split_wb_cache`

## Requirements
- R1: After reset every block is invalid. `mem_req`, `flush_done` and `req_ready` are low while no request is presented.
- R2: A read that misses on a clean or empty block fetches every word of the block from memory, from word 0 upward. It then raises `req_ready` with the addressed word on `req_rdata`.
- R3: A request that hits raises `req_ready` in the same cycle as `req_valid` and causes no memory transfer. `req_ready` is never high without `req_valid`.
- R4: A store hit changes only the cached copy and causes no memory write. A later read of that word returns the stored value.
- R5: On a store, bit i of `req_be` selects bits 8i+7..8i of the word. Unselected bytes keep their previous value.
- R6: A store miss reads the full block from memory first and then merges the store into the cached block. It writes nothing to memory at that time.
- R7: A miss on a valid dirty block first writes every victim word, from word 0 upward, at the victim's own address. All of these writes happen before the first refill read.
- R8: Placement is direct-mapped. Two addresses with the same index and different tags evict each other.
- R9: With `SPLIT_EN`=1, data uses index values below NUM_BLKS/2 and instructions use those at or above it. The index is {req_instr, address index bits without the top one}. A fetch and a data access to the same address occupy different blocks. Data addresses that differ only in the top address index bit conflict.
- R10: A pulse on `flush_req` writes back every dirty block and no clean one, in ascending block order, and invalidates all blocks. It then raises `flush_done` for exactly one cycle. Every later access misses.
- R11: Once raised, `mem_req` stays high with a stable address, direction and write data until `mem_ack`. Only one memory transfer is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request served on this edge |
| req_addr | input | ADDR_W | Byte address |
| req_we | input | 1 | 1 = store, 0 = read |
| req_be | input | DATA_W/8 | Byte enables for stores |
| req_wdata | input | DATA_W | Store data |
| req_instr | input | 1 | 1 = instruction fetch, 0 = data access |
| req_rdata | output | DATA_W | Read data, valid with req_ready |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write to memory, 0 = read |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_wdata | output | DATA_W | Write-back data |
| mem_ack | input | 1 | Memory completes the transfer |
| mem_rdata | input | DATA_W | Refill data, valid with mem_ack |
| flush_req | input | 1 | Start a flush (pulse) |
| flush_done | output | 1 | One-cycle flush completion pulse |

## Verification
A lost dirty bit or a wrong tag does not show at the ports straight away. It shows later, when that block is evicted: the victim write-back is missing or goes to the wrong address, and a later refill returns stale memory contents. The bench therefore counts memory reads and writes for every access and logs their addresses. It also rereads stored words after they have been evicted and refilled. A mistake in the split index shows as an extra refill, or as a missing one, on the first instruction or data access that should have shared or avoided a block.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

    typedef enum logic [2:0] {
        CS_IDLE,
        CS_EVICT,
        CS_FILL,
        CS_SCAN,
        CS_SCAN_WB,
        CS_SCAN_END
    } cache_state_e;

    typedef struct packed {
        logic valid;
        logic dirty;
    } blk_flags_t;

    localparam int unsigned BYTE_BITS = 8;

endpackage

// File: rtl/wbc_tag_store.sv
module wbc_tag_store
    import wbc_pkg::*;
#(
    parameter int unsigned NUM_BLKS = 8,
    parameter int unsigned TAG_W    = 8,
    localparam int unsigned IDX_W   = $clog2(NUM_BLKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  idx,
    input  logic              fill_we,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic              dirty_set,
    input  logic              inv_we,
    output blk_flags_t        cur_flags,
    output logic [TAG_W-1:0]  cur_tag
);

    blk_flags_t       flags [NUM_BLKS];
    logic [TAG_W-1:0] tags  [NUM_BLKS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_BLKS; i++) begin
                flags[i] <= '0;
            end
        end else if (fill_we) begin
            flags[idx] <= '{valid: 1'b1, dirty: 1'b0};
        end else if (dirty_set) begin
            flags[idx].dirty <= 1'b1;
        end else if (inv_we) begin
            flags[idx] <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_we) begin
            tags[idx] <= fill_tag;
        end
    end

    assign cur_flags = flags[idx];
    assign cur_tag   = tags[idx];

endmodule

// File: rtl/wbc_data_store.sv
module wbc_data_store
    import wbc_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned NUM_BLKS  = 8,
    parameter int unsigned BLK_WORDS = 4,
    localparam int unsigned DEPTH    = NUM_BLKS * BLK_WORDS,
    localparam int unsigned AW       = $clog2(DEPTH),
    localparam int unsigned BE_W     = DATA_W / BYTE_BITS
) (
    input  logic              clk,
    input  logic [AW-1:0]     addr,
    input  logic              we,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] words [DEPTH];
    logic [DATA_W-1:0] merged;

    assign rdata = words[addr];

    for (genvar b = 0; b < BE_W; b++) begin : g_lane
        assign merged[b*BYTE_BITS +: BYTE_BITS] =
            be[b] ? wdata[b*BYTE_BITS +: BYTE_BITS] : rdata[b*BYTE_BITS +: BYTE_BITS];
    end

    always_ff @(posedge clk) begin
        if (we) begin
            words[addr] <= merged;
        end
    end

endmodule

// File: rtl/wbc_ctrl.sv
module wbc_ctrl
    import wbc_pkg::*;
#(
    parameter int unsigned WSEL_W = 2,
    parameter int unsigned IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_hit,
    input  blk_flags_t        cur_flags,
    input  logic              flush_req,
    input  logic              mem_ack,
    output cache_state_e      state,
    output logic [WSEL_W-1:0] word_cnt,
    output logic [IDX_W-1:0]  scan_idx,
    output logic              use_scan,
    output logic              req_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic              fill_word,
    output logic              fill_last,
    output logic              inv_we,
    output logic              flush_done
);

    cache_state_e      state_d;
    logic [WSEL_W-1:0] cnt_d;
    logic [IDX_W-1:0]  scan_d;
    logic              flush_pend;
    logic              last_word;
    logic              last_blk;

    assign last_word = (word_cnt == {WSEL_W{1'b1}});
    assign last_blk  = (scan_idx == {IDX_W{1'b1}});
    assign use_scan  = (state == CS_SCAN) || (state == CS_SCAN_WB);

    always_comb begin
        state_d    = state;
        cnt_d      = word_cnt;
        scan_d     = scan_idx;
        req_ready  = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        fill_word  = 1'b0;
        fill_last  = 1'b0;
        inv_we     = 1'b0;
        flush_done = 1'b0;
        unique case (state)
            CS_IDLE: begin
                req_ready = req_valid && req_hit && !flush_pend;
                cnt_d     = '0;
                if (flush_pend) begin
                    scan_d  = '0;
                    state_d = CS_SCAN;
                end else if (req_valid && !req_hit) begin
                    state_d = (cur_flags.valid && cur_flags.dirty) ? CS_EVICT : CS_FILL;
                end
            end
            CS_EVICT: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) begin
                    cnt_d = word_cnt + 1'b1;
                    if (last_word) begin
                        state_d = CS_FILL;
                    end
                end
            end
            CS_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    fill_word = 1'b1;
                    cnt_d     = word_cnt + 1'b1;
                    if (last_word) begin
                        fill_last = 1'b1;
                        state_d   = CS_IDLE;
                    end
                end
            end
            CS_SCAN: begin
                cnt_d = '0;
                if (cur_flags.valid && cur_flags.dirty) begin
                    state_d = CS_SCAN_WB;
                end else begin
                    inv_we  = 1'b1;
                    scan_d  = scan_idx + 1'b1;
                    state_d = last_blk ? CS_SCAN_END : CS_SCAN;
                end
            end
            CS_SCAN_WB: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) begin
                    cnt_d = word_cnt + 1'b1;
                    if (last_word) begin
                        inv_we  = 1'b1;
                        scan_d  = scan_idx + 1'b1;
                        state_d = last_blk ? CS_SCAN_END : CS_SCAN;
                    end
                end
            end
            CS_SCAN_END: begin
                flush_done = 1'b1;
                state_d    = CS_IDLE;
            end
            default: state_d = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= CS_IDLE;
            word_cnt   <= '0;
            scan_idx   <= '0;
            flush_pend <= 1'b0;
        end else begin
            state      <= state_d;
            word_cnt   <= cnt_d;
            scan_idx   <= scan_d;
            flush_pend <= (flush_pend || flush_req) && !(state == CS_IDLE && flush_pend);
        end
    end

endmodule

// File: rtl/split_wb_cache.sv
module split_wb_cache
    import wbc_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned BLK_WORDS = 4,
    parameter int unsigned NUM_BLKS  = 8,
    parameter bit          SPLIT_EN  = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic                     req_we,
    input  logic [DATA_W/8-1:0]      req_be,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic                     req_instr,
    output logic [DATA_W-1:0]        req_rdata,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [DATA_W-1:0]        mem_wdata,
    input  logic                     mem_ack,
    input  logic [DATA_W-1:0]        mem_rdata,
    input  logic                     flush_req,
    output logic                     flush_done
);

    localparam int unsigned BE_W   = DATA_W / BYTE_BITS;
    localparam int unsigned OFS_W  = $clog2(BE_W);
    localparam int unsigned WSEL_W = $clog2(BLK_WORDS);
    localparam int unsigned IDX_W  = $clog2(NUM_BLKS);
    localparam int unsigned TAG_W  = ADDR_W - OFS_W - WSEL_W;
    localparam int unsigned IDX_LO = OFS_W + WSEL_W;

    cache_state_e      state;
    logic [WSEL_W-1:0] word_cnt;
    logic [IDX_W-1:0]  scan_idx;
    logic              use_scan;
    logic              fill_word;
    logic              fill_last;
    logic              inv_we;
    logic              hit;
    blk_flags_t        cur_flags;
    logic [TAG_W-1:0]  cur_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [IDX_W-1:0]  blk_idx;
    logic [TAG_W-1:0]  req_tag;
    logic [WSEL_W-1:0] req_wsel;
    logic [WSEL_W-1:0] dat_wsel;
    logic              dat_we;
    logic [BE_W-1:0]   dat_be;
    logic [DATA_W-1:0] dat_wdata;
    logic [DATA_W-1:0] dat_rdata;
    logic              from_victim;
    logic [TAG_W-1:0]  out_tag;

    if (SPLIT_EN) begin : g_split_idx
        if (IDX_W > 1) begin : g_wide
            assign req_idx = {req_instr, req_addr[IDX_LO +: IDX_W-1]};
        end else begin : g_narrow
            assign req_idx = req_instr;
        end
    end else begin : g_flat_idx
        assign req_idx = req_addr[IDX_LO +: IDX_W];
    end

    assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
    assign req_wsel = req_addr[OFS_W +: WSEL_W];
    assign blk_idx  = use_scan ? scan_idx : req_idx;
    assign hit      = cur_flags.valid && (cur_tag == req_tag);

    wbc_ctrl #(
        .WSEL_W (WSEL_W),
        .IDX_W  (IDX_W)
    ) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_hit    (hit),
        .cur_flags  (cur_flags),
        .flush_req  (flush_req),
        .mem_ack    (mem_ack),
        .state      (state),
        .word_cnt   (word_cnt),
        .scan_idx   (scan_idx),
        .use_scan   (use_scan),
        .req_ready  (req_ready),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .fill_word  (fill_word),
        .fill_last  (fill_last),
        .inv_we     (inv_we),
        .flush_done (flush_done)
    );

    wbc_tag_store #(
        .NUM_BLKS (NUM_BLKS),
        .TAG_W    (TAG_W)
    ) tags_i (
        .clk       (clk),
        .rst       (rst),
        .idx       (blk_idx),
        .fill_we   (fill_last),
        .fill_tag  (req_tag),
        .dirty_set (req_ready && req_we),
        .inv_we    (inv_we),
        .cur_flags (cur_flags),
        .cur_tag   (cur_tag)
    );

    assign dat_wsel  = (state == CS_IDLE) ? req_wsel : word_cnt;
    assign dat_we    = fill_word || (req_ready && req_we);
    assign dat_be    = fill_word ? {BE_W{1'b1}} : req_be;
    assign dat_wdata = fill_word ? mem_rdata : req_wdata;

    wbc_data_store #(
        .DATA_W    (DATA_W),
        .NUM_BLKS  (NUM_BLKS),
        .BLK_WORDS (BLK_WORDS)
    ) data_i (
        .clk   (clk),
        .addr  ({blk_idx, dat_wsel}),
        .we    (dat_we),
        .be    (dat_be),
        .wdata (dat_wdata),
        .rdata (dat_rdata)
    );

    assign from_victim = (state == CS_EVICT) || (state == CS_SCAN_WB);
    assign out_tag     = from_victim ? cur_tag : req_tag;
    assign mem_addr    = {out_tag, word_cnt, {OFS_W{1'b0}}};
    assign mem_wdata   = dat_rdata;
    assign req_rdata   = dat_rdata;

endmodule

// File: rtl/wbc_chk.sv
module wbc_chk #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_we,
    input logic              req_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              flush_done
);

    // R1
    quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!mem_req && !flush_done));

    // R3
    ready_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (req_valid && !mem_req));

    // R4
    store_hit_no_mem_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_we) |=> !mem_req);

    // R7
    evict_then_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && $fell(mem_we)) |-> $past(mem_ack));

    // R10
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        flush_done |=> !flush_done);

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && (!mem_we || $stable(mem_wdata))));

endmodule

bind split_wb_cache wbc_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_we     (req_we),
    .req_ready  (req_ready),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .flush_done (flush_done)
);

// File: tb/split_wb_cache_tb_top.sv
module split_wb_cache_tb_top;

    typedef struct packed {
        logic        we;
        logic        ins;
        logic [3:0]  be;
        logic [11:0] addr;
        logic [31:0] wd;
        logic [3:0]  nr;
        logic [3:0]  nw;
    } vec_t;

    // geometry: 16-byte blocks, 8 blocks, split on; data idx 0..3, instr idx 4..7
    localparam vec_t VECS [16] = '{
        '{1'b0, 1'b0, 4'hF, 12'h000, 32'h0,         4'd4, 4'd0},  // R2 cold read
        '{1'b0, 1'b0, 4'hF, 12'h004, 32'h0,         4'd0, 4'd0},  // R3 hit
        '{1'b1, 1'b0, 4'hF, 12'h008, 32'h11112222,  4'd0, 4'd0},  // R4 store hit
        '{1'b0, 1'b0, 4'hF, 12'h008, 32'h0,         4'd0, 4'd0},  // R4 readback
        '{1'b1, 1'b0, 4'h3, 12'h00C, 32'h5555BEEF,  4'd0, 4'd0},  // R5 low half
        '{1'b0, 1'b0, 4'hF, 12'h00C, 32'h0,         4'd0, 4'd0},  // R5 merged
        '{1'b0, 1'b1, 4'hF, 12'h000, 32'h0,         4'd4, 4'd0},  // R9 fetch own half
        '{1'b0, 1'b0, 4'hF, 12'h000, 32'h0,         4'd0, 4'd0},  // R9 data kept
        '{1'b0, 1'b0, 4'hF, 12'h040, 32'h0,         4'd4, 4'd4},  // R7 R8 R9 dirty conflict
        '{1'b0, 1'b0, 4'hF, 12'h008, 32'h0,         4'd4, 4'd0},  // R7 written back value
        '{1'b1, 1'b0, 4'hF, 12'h104, 32'hA0A0B0B0,  4'd4, 4'd0},  // R6 store miss
        '{1'b0, 1'b0, 4'hF, 12'h104, 32'h0,         4'd0, 4'd0},  // R6 allocated
        '{1'b0, 1'b0, 4'hF, 12'h030, 32'h0,         4'd4, 4'd0},  // R2 other block
        '{1'b0, 1'b1, 4'hF, 12'h030, 32'h0,         4'd4, 4'd0},  // R9 same addr fetch
        '{1'b0, 1'b1, 4'hF, 12'h070, 32'h0,         4'd4, 4'd0},  // R8 instr conflict
        '{1'b1, 1'b0, 4'hC, 12'h034, 32'h7777EEEE,  4'd0, 4'd0}   // R5 high half
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [11:0] req_addr = '0;
    logic        req_we = 1'b0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        req_instr = 1'b0;
    logic [31:0] req_rdata;
    logic        mem_req;
    logic        mem_we;
    logic [11:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack;
    logic [31:0] mem_rdata;
    logic        flush_req = 1'b0;
    logic        flush_done;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [31:0] mdl [1024];
    logic [31:0] ref_mem [1024];
    int          lat_cnt;
    int          n_rd, n_wr, op_n, n_done;
    logic [11:0] op_addr [256];
    logic        op_we [256];

    always #5 clk = ~clk;

    split_wb_cache dut_i (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_we     (req_we),
        .req_be     (req_be),
        .req_wdata  (req_wdata),
        .req_instr  (req_instr),
        .req_rdata  (req_rdata),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .flush_req  (flush_req),
        .flush_done (flush_done)
    );

    // slow memory: ack two cycles after a request is seen
    assign mem_rdata = mdl[mem_addr[11:2]];

    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            lat_cnt <= 0;
            n_rd    <= 0;
            n_wr    <= 0;
            op_n    <= 0;
            n_done  <= 0;
            for (int i = 0; i < 1024; i++) mdl[i] <= 32'hC0DE0000 | i;
        end else begin
            if (flush_done) n_done <= n_done + 1;
            if (mem_req && mem_ack) begin
                mem_ack <= 1'b0;
                if (mem_we) begin
                    mdl[mem_addr[11:2]] <= mem_wdata;
                    n_wr <= n_wr + 1;
                end else begin
                    n_rd <= n_rd + 1;
                end
                op_addr[op_n[7:0]] <= mem_addr;
                op_we[op_n[7:0]]   <= mem_we;
                op_n <= op_n + 1;
            end else if (mem_req) begin
                if (lat_cnt == 1) begin
                    mem_ack <= 1'b1;
                    lat_cnt <= 0;
                end else begin
                    lat_cnt <= lat_cnt + 1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic access(input logic we, input logic ins, input logic [3:0] be,
                          input logic [11:0] addr, input logic [31:0] wd,
                          output logic [31:0] rd);
        @(negedge clk);
        req_valid = 1'b1;
        req_we    = we;
        req_instr = ins;
        req_be    = be;
        req_addr  = addr;
        req_wdata = wd;
        while (!req_ready) @(negedge clk);
        rd = req_rdata;
        if (we) begin
            for (int b = 0; b < 4; b++)
                if (be[b]) ref_mem[addr[11:2]][b*8 +: 8] = wd[b*8 +: 8];
        end
        @(negedge clk);
        req_valid = 1'b0;
        req_we    = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        logic [31:0] rd;
        string       tag;
        int          r0, w0, s0;
        for (int i = 0; i < 1024; i++) ref_mem[i] = 32'hC0DE0000 | i;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!mem_req, "R1 mem_req after reset", {31'b0, mem_req}, 32'h0);
        check(!flush_done, "R1 flush_done after reset", {31'b0, flush_done}, 32'h0);
        check(!req_ready, "R1 req_ready idle", {31'b0, req_ready}, 32'h0);

        foreach (VECS[k]) begin
            tag = $sformatf("row%0d", k);
            r0 = n_rd;
            w0 = n_wr;
            s0 = op_n;
            access(VECS[k].we, VECS[k].ins, VECS[k].be, VECS[k].addr, VECS[k].wd, rd);
            check(n_rd - r0 == int'(VECS[k].nr), {tag, " memory reads (R2/R3/R6/R8/R9)"},
                  n_rd - r0, VECS[k].nr);
            check(n_wr - w0 == int'(VECS[k].nw), {tag, " memory writes (R4/R6/R7)"},
                  n_wr - w0, VECS[k].nw);
            if (!VECS[k].we)
                check(rd == ref_mem[VECS[k].addr[11:2]], {tag, " read data (R2/R4/R5)"},
                      rd, ref_mem[VECS[k].addr[11:2]]);
            if (k == 0) begin
                // R2 refill ascending from word 0
                for (int j = 0; j < 4; j++)
                    check(op_addr[s0 + j] == 12'h000 + 12'(4 * j) && !op_we[s0 + j],
                          "R2 refill order", {20'b0, op_addr[s0 + j]}, 32'(4 * j));
            end
            if (k == 8) begin
                // R7 victim words first, then refill words
                for (int j = 0; j < 4; j++) begin
                    check(op_we[s0 + j] && op_addr[s0 + j] == 12'(4 * j),
                          "R7 victim write order", {20'b0, op_addr[s0 + j]}, 32'(4 * j));
                    check(!op_we[s0 + 4 + j] && op_addr[s0 + 4 + j] == 12'h040 + 12'(4 * j),
                          "R7 refill after write-back", {20'b0, op_addr[s0 + 4 + j]},
                          32'h40 + 32'(4 * j));
                end
                check(mdl[3] == 32'hC0DEBEEF, "R5 merged word written back", mdl[3], 32'hC0DEBEEF);
            end
        end

        // R10 flush: blocks holding 0x100 and 0x030 are dirty
        r0 = n_rd;
        w0 = n_wr;
        s0 = op_n;
        @(negedge clk);
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
        while (n_done == 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(n_done == 1, "R10 single done pulse", n_done, 1);
        check(n_wr - w0 == 8, "R10 dirty words written", n_wr - w0, 8);
        check(n_rd - r0 == 0, "R10 no reads during flush", n_rd - r0, 0);
        check(op_addr[s0] == 12'h100, "R10 first block written", {20'b0, op_addr[s0]}, 32'h100);
        check(op_addr[s0 + 4] == 12'h030, "R10 second block written", {20'b0, op_addr[s0 + 4]}, 32'h30);
        check(mdl[12'h104 >> 2] == ref_mem[12'h104 >> 2], "R10 stored word in memory",
              mdl[12'h104 >> 2], ref_mem[12'h104 >> 2]);
        check(mdl[12'h034 >> 2] == ref_mem[12'h034 >> 2], "R10 byte-merged word in memory",
              mdl[12'h034 >> 2], ref_mem[12'h034 >> 2]);

        r0 = n_rd;
        access(1'b0, 1'b0, 4'hF, 12'h104, 32'h0, rd);
        check(n_rd - r0 == 4, "R10 data block invalidated", n_rd - r0, 4);
        check(rd == 32'hA0A0B0B0, "R10 data survives flush", rd, 32'hA0A0B0B0);
        r0 = n_rd;
        access(1'b0, 1'b1, 4'hF, 12'h070, 32'h0, rd);
        check(n_rd - r0 == 4, "R10 instr block invalidated", n_rd - r0, 4);

        summary();
    end

endmodule